// File: doc/BRIEF.md
# Sixteen-Bit ALU With Registered Flag Word

The block computes one of six arithmetic or logic functions on two 16-bit operands and presents the result combinationally. Alongside the result it derives a set of status conditions (carry or borrow, even parity of the low byte, nibble carry, zero, sign and signed overflow). These are captured into a 16-bit flag word only on a clock edge where the update strobe is high. The same word holds three control bits (single-step, interrupt enable, direction), each loaded by its own set and clear inputs.

A surrounding datapath drives the operands and the function code every cycle. It reads the result in the same cycle and raises the strobe when the operation should be recorded in the flags. A decrement leaves the carry bit untouched, so a multi-word count can keep a pending carry across it.

Top module: `alu16_flags`

## Requirements
- R1: `result` is combinational from `op_a`, `op_b` and `func`. The codes are 0 add (A+B), 1 subtract (A-B), 2 decrement (A-1), 3 AND, 4 OR and 5 NOT A. Codes 6 and 7 pass A through and count as logic operations.
- R2: Flag bit 0 (carry) is set on a carry out of bit 15 for add, and on a borrow into bit 15 (A < B unsigned) for subtract.
- R3: Flag bit 4 (nibble carry) is set on a carry out of bit 3 for add, and on a borrow from bit 4 for subtract and decrement.
- R4: Flag bit 2 (parity) is set when bits 7..0 of the result hold an even number of ones. Bits 15..8 have no effect on it.
- R5: Flag bit 6 (zero) is set when the result is 0. Flag bit 7 (sign) equals result bit 15.
- R6: Flag bit 11 (overflow) is set on two's-complement overflow for add, subtract and decrement. For decrement this is exactly the case A = 0x8000.
- R7: Codes 3 to 7 clear carry, overflow and nibble carry when flags are updated.
- R8: Decrement updates every status flag except carry, which keeps its earlier value.
- R9: Status flags change only on a rising clock edge with `upd_flags` high. Otherwise they hold while `result` still follows the inputs.
- R10: Control bits 8 (single-step), 9 (interrupt enable) and 10 (direction) are set by their set input and cleared by their clear input at any clock edge, regardless of `upd_flags`. Clear wins when both are high. Status bits are unaffected.
- R11: Reset (`rst_n` low) makes the flag word 0x0002. Bit 1 always reads 1, and bits 3, 5 and 15..12 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| func | input | 3 | Function code |
| upd_flags | input | 1 | Capture status flags at this edge |
| set_tf | input | 1 | Set single-step bit |
| clr_tf | input | 1 | Clear single-step bit |
| set_if | input | 1 | Set interrupt-enable bit |
| clr_if | input | 1 | Clear interrupt-enable bit |
| set_df | input | 1 | Set direction bit |
| clr_df | input | 1 | Clear direction bit |
| result | output | 16 | Combinational result |
| flags | output | 16 | Registered flag word |

## Verification
The add tests use operand pairs chosen to separate the flags. 0xFFFF+1 wraps to zero. 0x7FFF+1 overflows into the sign bit without an unsigned carry. 0x0008+0x0008 carries only out of the low nibble. Together these show that carry, overflow and nibble carry come from different bit positions. The subtract tests cover a borrow from zero, 0x8000-1 overflow and equal operands. Decrement is run with carry both preset and clear to show that carry is held. The logic tests follow a carry-producing add, so the clearing of carry, overflow and nibble carry can be observed. Parity is tried on results whose high byte is full and whose low byte is empty or odd, which shows that only the low byte counts.

// File: rtl/alu16_flags.sv
module alu16_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   func,
  input  logic         upd_flags,
  input  logic         set_tf,
  input  logic         clr_tf,
  input  logic         set_if,
  input  logic         clr_if,
  input  logic         set_df,
  input  logic         clr_df,
  output logic [W-1:0] result,
  output logic [15:0]  flags
);
  localparam int M = W - 1;
  localparam logic [2:0] F_ADD = 3'd0, F_SUB = 3'd1, F_DEC = 3'd2,
                         F_AND = 3'd3, F_OR  = 3'd4, F_NOT = 3'd5;

  logic         is_arith, is_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   ext;
  logic [4:0]   nib;
  logic         n_cf, n_af, n_of;
  logic         cf, pf, af, zf, sf, of, tf, ief, df;

  assign is_arith = (func == F_ADD) || (func == F_SUB) || (func == F_DEC);
  assign is_sub   = (func == F_SUB) || (func == F_DEC);
  assign b_eff    = (func == F_DEC) ? W'(1) : op_b;

  always_comb begin
    case (func)
      F_ADD:   ext = {1'b0, op_a} + {1'b0, b_eff};
      F_SUB,
      F_DEC:   ext = {1'b0, op_a} - {1'b0, b_eff};
      F_AND:   ext = {1'b0, op_a & op_b};
      F_OR:    ext = {1'b0, op_a | op_b};
      F_NOT:   ext = {1'b0, ~op_a};
      default: ext = {1'b0, op_a};
    endcase
  end

  assign nib    = is_sub ? ({1'b0, op_a[3:0]} - {1'b0, b_eff[3:0]})
                         : ({1'b0, op_a[3:0]} + {1'b0, b_eff[3:0]});
  assign result = ext[M:0];

  assign n_cf = (func == F_DEC) ? cf : (is_arith & ext[W]);
  assign n_af = is_arith & nib[4];
  assign n_of = is_arith & (is_sub ? (op_a[M] != b_eff[M]) : (op_a[M] == b_eff[M]))
                         & (result[M] != op_a[M]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cf, pf, af, zf, sf, of} <= '0;
    end else if (upd_flags) begin
      cf <= n_cf;
      pf <= ~^result[7:0];
      af <= n_af;
      zf <= (result == '0);
      sf <= result[M];
      of <= n_of;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tf, ief, df} <= '0;
    end else begin
      tf  <= clr_tf ? 1'b0 : (set_tf ? 1'b1 : tf);
      ief <= clr_if ? 1'b0 : (set_if ? 1'b1 : ief);
      df  <= clr_df ? 1'b0 : (set_df ? 1'b1 : df);
    end
  end

  assign flags = {4'b0000, of, df, ief, tf, sf, zf, 1'b0, af, 1'b0, pf, 1'b1, cf};

  a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    upd_flags && func == F_ADD |=> flags[0] == ($past(op_a) > ~$past(op_b)));
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    upd_flags && result == '0 |=> flags[6]);
  a_r7_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    upd_flags && !is_arith |=> !flags[0] && !flags[4] && !flags[11]);
  a_r8_dec_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    upd_flags && func == F_DEC |=> flags[0] == $past(flags[0]));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_flags |=> flags[7:0] == $past(flags[7:0]) && flags[11] == $past(flags[11]));
  a_r10_tf_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tf |=> !flags[8]);
  a_r10_if_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_if && !clr_if |=> flags[9]);
endmodule

// File: tb/test_alu16_flags.sv
module test_alu16_flags;
  logic        clk = 0, rst_n = 0;
  logic [15:0] op_a = 0, op_b = 0;
  logic [2:0]  func = 0;
  logic        upd_flags = 0;
  logic        set_tf = 0, clr_tf = 0, set_if = 0, clr_if = 0, set_df = 0, clr_df = 0;
  logic [15:0] result, flags;
  logic [15:0] exp_flags;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  alu16_flags i_alu16_flags (.clk, .rst_n, .op_a, .op_b, .func, .upd_flags,
    .set_tf, .clr_tf, .set_if, .clr_if, .set_df, .clr_df, .result, .flags);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl_res(logic [2:0] f, logic [15:0] a, logic [15:0] b);
    case (f)
      0: return a + b;
      1: return a - b;
      2: return a - 16'd1;
      3: return a & b;
      4: return a | b;
      5: return ~a;
      default: return a;
    endcase
  endfunction

  function automatic logic [15:0] mdl_flags(logic [2:0] f, logic [15:0] a, logic [15:0] b,
                                            logic [15:0] prev);
    logic [15:0] r = mdl_res(f, a, b);
    logic [15:0] nf = prev;
    int sa = int'($signed(a));
    int sb = int'($signed(b));
    int s;
    nf[2] = ~^r[7:0];
    nf[6] = (r == 0);
    nf[7] = r[15];
    case (f)
      0: begin
        nf[0] = (int'(a) + int'(b)) > 65535;
        nf[4] = (int'(a[3:0]) + int'(b[3:0])) > 15;
        s = sa + sb;
        nf[11] = (s > 32767) || (s < -32768);
      end
      1: begin
        nf[0] = a < b;
        nf[4] = a[3:0] < b[3:0];
        s = sa - sb;
        nf[11] = (s > 32767) || (s < -32768);
      end
      2: begin
        nf[4] = (a[3:0] == 0);
        nf[11] = (a == 16'h8000);
      end
      default: begin
        nf[0] = 0; nf[4] = 0; nf[11] = 0;
      end
    endcase
    return nf;
  endfunction

  task automatic do_op(string req, logic [2:0] f, logic [15:0] a, logic [15:0] b);
    func = f; op_a = a; op_b = b; upd_flags = 1;
    #1 chk({req, " result"}, result, mdl_res(f, a, b));
    exp_flags = mdl_flags(f, a, b, exp_flags);
    @(posedge clk); @(negedge clk);
    upd_flags = 0;
    chk({req, " flags"}, flags, exp_flags);
  endtask

  task automatic t_reset();
    exp_flags = 16'h0002;
    chk("R11 reset word", flags, 16'h0002);
  endtask

  task automatic t_add();
    do_op("R2 R5 add wrap", 0, 16'hFFFF, 16'h0001);
    do_op("R6 add overflow", 0, 16'h7FFF, 16'h0001);
    do_op("R3 add nibble", 0, 16'h0008, 16'h0008);
    do_op("R1 add plain", 0, 16'h1234, 16'h0101);
  endtask

  task automatic t_sub();
    do_op("R2 R3 sub borrow", 1, 16'h0000, 16'h0001);
    do_op("R6 sub overflow", 1, 16'h8000, 16'h0001);
    do_op("R5 sub equal", 1, 16'h5A5A, 16'h5A5A);
  endtask

  task automatic t_dec();
    do_op("R2 set carry", 0, 16'hFFFF, 16'h0002);
    do_op("R8 dec keeps carry set", 2, 16'h0010, 16'h0000);
    chk("R8 carry still 1", {15'd0, flags[0]}, 16'd1);
    do_op("R2 clear carry", 0, 16'h0001, 16'h0001);
    do_op("R6 R8 dec 8000", 2, 16'h8000, 16'h0000);
    do_op("R5 dec to zero", 2, 16'h0001, 16'h0000);
  endtask

  task automatic t_logic();
    do_op("R2 carry before logic", 0, 16'h8FFF, 16'h8001);
    do_op("R7 and", 3, 16'hF0F0, 16'hFF00);
    do_op("R6 overflow before logic", 0, 16'h7FFF, 16'h7FFF);
    do_op("R7 or", 4, 16'h0F00, 16'h00F1);
    do_op("R7 not", 5, 16'h00FF, 16'h0000);
    do_op("R1 code6 pass", 6, 16'hABCD, 16'h1111);
    do_op("R1 code7 pass", 7, 16'h0000, 16'h1111);
  endtask

  task automatic t_parity();
    do_op("R4 high byte full low empty", 3, 16'hFF00, 16'hFFFF);
    chk("R4 parity set", {15'd0, flags[2]}, 16'd1);
    do_op("R4 high byte full low odd", 4, 16'hFF00, 16'h0001);
    chk("R4 parity clear", {15'd0, flags[2]}, 16'd0);
  endtask

  task automatic t_hold();
    func = 0; op_a = 16'hFFFF; op_b = 16'hFFFF; upd_flags = 0;
    #1 chk("R9 result comb", result, 16'hFFFE);
    @(posedge clk); @(negedge clk);
    chk("R9 flags held", flags, exp_flags);
    op_a = 16'h0000; op_b = 16'h0000;
    #1 chk("R9 result follows", result, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R9 flags held zero", flags, exp_flags);
  endtask

  task automatic t_ctrl();
    set_tf = 1; set_if = 1; set_df = 1;
    @(posedge clk); @(negedge clk);
    set_tf = 0; set_if = 0; set_df = 0;
    exp_flags[10:8] = 3'b111;
    chk("R10 set all control", flags, exp_flags);
    set_if = 1; clr_if = 1; clr_df = 1;
    @(posedge clk); @(negedge clk);
    set_if = 0; clr_if = 0; clr_df = 0;
    exp_flags[9] = 0; exp_flags[10] = 0;
    chk("R10 clear wins", flags, exp_flags);
    do_op("R10 status update keeps tf", 0, 16'h0001, 16'h0001);
    clr_tf = 1;
    @(posedge clk); @(negedge clk);
    clr_tf = 0;
    exp_flags[8] = 0;
    chk("R10 clear tf", flags, exp_flags);
    chk("R11 reserved bits", flags & 16'hF02A, 16'h0002);
  endtask

  initial begin
    #100000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R11 in reset", flags, 16'h0002);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_dec();
    t_logic();
    t_parity();
    t_hold();
    t_ctrl();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule